// File: doc/BRIEF.md
# Dual-CPU Two-Gate Interrupt Controller

This block collects level-sensitive interrupt lines from devices and presents them to a small cluster of processors. Each line must clear two independent gates before it can reach a processor: a single global enable shared by every CPU, then a per-CPU mask owned by each processor. A routing word per line selects which processors may receive it. For every CPU the block keeps a registered winner: the lowest-numbered line that is asserted, enabled, unmasked for that CPU and routed to it. The winner drives that CPU's interrupt output and is returned by its acknowledge register.

Software never edits enable or mask bitmaps directly. It writes a line number to a set or clear register, and only that line changes. Mask registers, and the acknowledge register, resolve to the processor that issues the access, which the bus names with a CPU index. Routing words are plain read/write registers that software updates with read-modify-write.

Accesses pass through a three-state sequencer. `ST_IDLE` accepts a request (`req_ready` high) and moves to `ST_EXEC` when `req_valid` is seen. `ST_EXEC` applies a write or captures read data, then always moves to `ST_RESP`. `ST_RESP` raises `rsp_valid` for one cycle with the read data, then always returns to `ST_IDLE`.

Top module: `irqc_top`

## Requirements
- R1: After reset every line is globally disabled, masked on every CPU and has a routing word of zero, so each CPU's acknowledge reads 1023, every `cpu_irq` bit is 0 and any routing word reads back 0.
- R2: A write of line number n (field [9:0]) to ENABLE_SET (0x010) enables line n globally; a write to ENABLE_CLR (0x014) disables it for all CPUs.
- R3: A write of n to MASK_SET (0x020) masks line n only for the CPU named by `req_cpu`; a write to MASK_CLR (0x024) unmasks it only for that CPU.
- R4: The routing word of line n lives at 0x200 + 4*n. Bit c is the normal route and bit 8+c the fast route for CPU c; either one delivers the line to CPU c. Only those bits are stored and all other bits read 0.
- R5: When several lines qualify for a CPU, its acknowledge (0x028, field [9:0], upper bits 0) returns the lowest line number.
- R6: Reading the acknowledge register clears nothing: a repeated read returns the same number while the source stays high, and the winner changes only when the source line drops.
- R7: The information register (0x000) returns the number of lines in bits [11:2] with all other bits 0; reads of undecoded addresses return 0, and writes respond with data 0.
- R8: `cpu_irq[c]` is high exactly when CPU c's acknowledge would return a line number, and follows a change in source, enable, mask or routing one clock after the change is registered.
- R9: A set or clear write whose number is not below the line count changes no state.
- R10: An accepted request gives exactly one `rsp_valid` pulse two clocks after acceptance; `req_ready` stays low from acceptance until the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Level-sensitive interrupt lines |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Index of the CPU issuing the access |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | High while a request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` |
| cpu_irq | output | NUM_CPU | Interrupt request to each CPU |

## Verification
The bench builds the block with NUM_SRC set to 40 and two CPUs. This puts a line number (37) above the 32-bit boundary, so priority picking and routing word addressing are checked past one word of state. It also makes the line count a value that is not a power of two, so a number such as 101, whose low six bits alias line 37, shows whether out-of-range numbers are rejected or silently truncated. With two CPUs, mask and route isolation between processors can be observed in both directions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_RESP
    } bus_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE
    } wr_op_e;

    localparam int unsigned ACK_W        = 10;
    localparam int unsigned SPURIOUS     = 1023;
    localparam int unsigned FAST_LSB     = 8;

    localparam int unsigned A_INFO       = 'h000;
    localparam int unsigned A_EN_SET     = 'h010;
    localparam int unsigned A_EN_CLR     = 'h014;
    localparam int unsigned A_MSK_SET    = 'h020;
    localparam int unsigned A_MSK_CLR    = 'h024;
    localparam int unsigned A_ACK        = 'h028;
    localparam int unsigned A_ROUTE_BASE = 'h200;

endpackage

// File: rtl/irqc_bus.sv
module irqc_bus
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CPU_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] rd_mux,
    output logic              req_ready,
    output logic              exec_en,
    output logic              lat_write,
    output logic [CPU_W-1:0]  lat_cpu,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    bus_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_cpu   <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rsp_rdata <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_cpu   <= req_cpu;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (state_q == ST_EXEC) begin
                rsp_rdata <= lat_write ? '0 : rd_mux;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        req_ready = 1'b0;
        exec_en   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_EXEC: exec_en   = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned CPU_W   = 1,
    parameter int unsigned SRC_W   = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  wr_op_e                            op,
    input  logic [CPU_W-1:0]                  op_cpu,
    input  logic [SRC_W-1:0]                  op_idx,
    input  logic [NUM_CPU-1:0]                op_norm,
    input  logic [NUM_CPU-1:0]                op_fast,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   rt_norm_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   rt_fast_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        logic hit;
        assign hit = (op_idx == SRC_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (hit && op == OP_EN_SET) begin
                en_q[i] <= 1'b1;
            end else if (hit && op == OP_EN_CLR) begin
                en_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rt_norm_q[i] <= '0;
                rt_fast_q[i] <= '0;
            end else if (hit && op == OP_ROUTE) begin
                rt_norm_q[i] <= op_norm;
                rt_fast_q[i] <= op_fast;
            end
        end

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic mine;
            assign mine = hit && (op_cpu == CPU_W'(c));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q[c][i] <= 1'b1;
                end else if (mine && op == OP_MSK_SET) begin
                    mask_q[c][i] <= 1'b1;
                end else if (mine && op == OP_MSK_CLR) begin
                    mask_q[c][i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] routed,
    output logic               hit_q,
    output logic [ACK_W-1:0]   ack_q
);

    logic [NUM_SRC-1:0] elig;
    logic               hit_d;
    logic [ACK_W-1:0]   num_d;

    assign elig = src & en & ~mask & routed;

    // lowest number wins: scan downward so the last match is the smallest
    always_comb begin
        hit_d = 1'b0;
        num_d = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit_d = 1'b1;
                num_d = ACK_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            ack_q <= ACK_W'(SPURIOUS);
        end else begin
            hit_q <= hit_d;
            ack_q <= hit_d ? num_d : ACK_W'(SPURIOUS);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);

    localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ACK_W-1:0]    NSRC_NUM  = ACK_W'(NUM_SRC);
    localparam logic [ADDR_W-3:0]   NSRC_WORD = (ADDR_W-2)'(NUM_SRC);
    localparam logic [ADDR_W-1:0]   RT_BASE   = ADDR_W'(A_ROUTE_BASE);

    logic              exec_en;
    logic              lat_write;
    logic [CPU_W-1:0]  lat_cpu;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] rd_mux;

    irqc_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CPU_W  (CPU_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cpu   (req_cpu),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_mux    (rd_mux),
        .req_ready (req_ready),
        .exec_en   (exec_en),
        .lat_write (lat_write),
        .lat_cpu   (lat_cpu),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // ---------------- address decode ----------------
    logic [ACK_W-1:0]  wr_num;
    logic              num_ok;
    logic [ADDR_W-1:0] rt_off;
    logic              rt_hit;
    logic [SRC_W-1:0]  rt_idx;
    wr_op_e            op;
    logic [SRC_W-1:0]  op_idx;

    assign wr_num = lat_wdata[ACK_W-1:0];
    assign num_ok = (wr_num < NSRC_NUM);
    assign rt_off = lat_addr - RT_BASE;
    assign rt_hit = (lat_addr >= RT_BASE) && (rt_off[1:0] == 2'b00)
                    && (rt_off[ADDR_W-1:2] < NSRC_WORD);
    assign rt_idx = SRC_W'(rt_off[ADDR_W-1:2]);

    always_comb begin
        op     = OP_NONE;
        op_idx = SRC_W'(wr_num);
        if (exec_en && lat_write) begin
            if (rt_hit) begin
                op     = OP_ROUTE;
                op_idx = rt_idx;
            end else if (num_ok) begin
                unique case (lat_addr)
                    ADDR_W'(A_EN_SET):  op = OP_EN_SET;
                    ADDR_W'(A_EN_CLR):  op = OP_EN_CLR;
                    ADDR_W'(A_MSK_SET): op = OP_MSK_SET;
                    ADDR_W'(A_MSK_CLR): op = OP_MSK_CLR;
                    default:            op = OP_NONE;
                endcase
            end
        end
    end

    // ---------------- gate and routing state ----------------
    logic [NUM_SRC-1:0]              en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] rt_norm_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] rt_fast_q;

    irqc_state #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W),
        .SRC_W   (SRC_W)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .op_cpu    (lat_cpu),
        .op_idx    (op_idx),
        .op_norm   (lat_wdata[NUM_CPU-1:0]),
        .op_fast   (lat_wdata[FAST_LSB +: NUM_CPU]),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .rt_norm_q (rt_norm_q),
        .rt_fast_q (rt_fast_q)
    );

    // ---------------- per-CPU winner selection ----------------
    logic [NUM_CPU-1:0][ACK_W-1:0] ack_all;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_pick
        logic [NUM_SRC-1:0] routed;
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_rt
            assign routed[i] = rt_norm_q[i][c] | rt_fast_q[i][c];
        end

        irqc_pick #(
            .NUM_SRC (NUM_SRC)
        ) u_pick (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_irq),
            .en     (en_q),
            .mask   (mask_q[c]),
            .routed (routed),
            .hit_q  (cpu_irq[c]),
            .ack_q  (ack_all[c])
        );
    end

    // ---------------- read data ----------------
    always_comb begin
        rd_mux = '0;
        if (rt_hit) begin
            rd_mux[NUM_CPU-1:0]            = rt_norm_q[rt_idx];
            rd_mux[FAST_LSB +: NUM_CPU]    = rt_fast_q[rt_idx];
        end else if (lat_addr == ADDR_W'(A_INFO)) begin
            rd_mux[2 +: ACK_W] = NSRC_NUM;
        end else if (lat_addr == ADDR_W'(A_ACK)) begin
            if (int'(lat_cpu) < NUM_CPU) rd_mux[ACK_W-1:0] = ack_all[lat_cpu];
            else                         rd_mux[ACK_W-1:0] = ACK_W'(SPURIOUS);
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CPU = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [NUM_SRC-1:0] src_irq,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_CPU-1:0] cpu_irq
);

    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10

    AST_RSP_TWO_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid); // R10

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> $past(|src_irq)); // R8

        AST_IRQ_HAS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> $past(|(src_irq & en_q))); // R2
    end

endmodule

bind irqc_top irqc_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .src_irq   (src_irq),
    .en_q      (en_q),
    .cpu_irq   (cpu_irq)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NSRC  = 40;
    localparam int unsigned NCPU  = 2;
    localparam int unsigned AW    = 12;
    localparam int unsigned DW    = 32;
    localparam int unsigned CW    = 1;
    localparam logic [31:0] SPUR  = 32'd1023;

    localparam logic [AW-1:0] A_INFO = 12'h000;
    localparam logic [AW-1:0] A_ENS  = 12'h010;
    localparam logic [AW-1:0] A_ENC  = 12'h014;
    localparam logic [AW-1:0] A_MKS  = 12'h020;
    localparam logic [AW-1:0] A_MKC  = 12'h024;
    localparam logic [AW-1:0] A_ACK  = 12'h028;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_irq = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [CW-1:0]   req_cpu = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_ready;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic [NCPU-1:0] cpu_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top #(
        .NUM_SRC (NSRC),
        .NUM_CPU (NCPU),
        .ADDR_W  (AW),
        .DATA_W  (DW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cpu   (req_cpu),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: each response is compared with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, rsp_rdata, it.exp);
            end
        end
    end

    // driver: issue one access at a negedge, push its expected response
    task automatic access(input bit wr, input int cpu, input logic [AW-1:0] addr,
                          input logic [31:0] wdata, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = wr ? 32'd0 : exp;
        it.tag = tag;
        exp_q.push_back(it);
        req_valid = 1'b1;
        req_write = wr;
        req_cpu   = CW'(cpu);
        req_addr  = addr;
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        check("R10 busy not ready", {31'd0, req_ready}, 32'd0);
        check("R10 early response", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        check("R10 response strobe", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
    endtask

    task automatic wr(input int cpu, input logic [AW-1:0] addr, input logic [31:0] d);
        access(1'b1, cpu, addr, d, 32'd0, "R7 write data zero");
    endtask

    task automatic rd(input int cpu, input logic [AW-1:0] addr, input logic [31:0] exp,
                      input string tag);
        access(1'b0, cpu, addr, 32'd0, exp, tag);
    endtask

    function automatic logic [AW-1:0] rt(input int n);
        return AW'(12'h200 + 4 * n);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cpu_irq after reset", {30'd0, cpu_irq}, 32'd0);
        rd(0, A_ACK, SPUR, "R1 ack cpu0 reset");
        rd(1, A_ACK, SPUR, "R1 ack cpu1 reset");
        rd(0, rt(7), 32'd0, "R1 route reset");
        // R7 information register and undecoded space
        rd(1, A_INFO, 32'(NSRC) << 2, "R7 line count");
        rd(0, 12'h030, 32'd0, "R7 undecoded read");

        src_irq = '1;
        @(negedge clk);
        check("R1 gates closed", {30'd0, cpu_irq}, 32'd0);

        // R2 enable, R3 mask isolation, R4 routing
        wr(0, A_ENS, 32'd5);
        wr(0, rt(5), 32'h1);
        rd(0, A_ACK, SPUR, "R3 still masked");
        wr(0, A_MKC, 32'd5);
        check("R8 cpu_irq cpu0 only", {30'd0, cpu_irq}, 32'd1);
        rd(0, A_ACK, 32'd5, "R3 unmasked cpu0");
        rd(1, A_ACK, SPUR, "R3 cpu1 unaffected");
        wr(1, A_MKC, 32'd5);
        rd(1, A_ACK, SPUR, "R4 not routed to cpu1");
        wr(0, rt(5), 32'h200);
        rd(1, A_ACK, 32'd5, "R4 fast route cpu1");
        rd(0, A_ACK, SPUR, "R4 route removed cpu0");
        check("R8 cpu_irq cpu1 only", {30'd0, cpu_irq}, 32'd2);
        wr(0, rt(5), 32'hFFFF_FFFF);
        rd(1, rt(5), 32'h303, "R4 route readback");

        // R5 lowest number wins
        wr(0, A_ENS, 32'd3);
        wr(0, A_ENS, 32'd37);
        wr(0, rt(3), 32'h1);
        wr(0, rt(37), 32'h1);
        wr(0, A_MKC, 32'd37);
        rd(0, A_ACK, 32'd5, "R5 five below 37");
        wr(0, A_MKC, 32'd3);
        rd(0, A_ACK, 32'd3, "R5 three wins");
        rd(1, A_ACK, 32'd5, "R5 cpu1 sees five");

        // R6 ack read clears nothing; source drop moves winner
        rd(0, A_ACK, 32'd3, "R6 repeat read");
        src_irq[3] = 1'b0;
        @(negedge clk);
        rd(0, A_ACK, 32'd5, "R6 after source drop");

        // R2 global disable
        wr(1, A_ENC, 32'd5);
        rd(0, A_ACK, 32'd37, "R2 disabled line skipped");
        rd(1, A_ACK, SPUR, "R2 disable hits all cpus");
        check("R8 irq pattern", {30'd0, cpu_irq}, 32'd1);

        // R3 mask set
        wr(0, A_MKS, 32'd37);
        rd(0, A_ACK, SPUR, "R3 mask set");
        check("R8 irq drops", {30'd0, cpu_irq}, 32'd0);
        wr(0, A_MKC, 32'd37);
        rd(0, A_ACK, 32'd37, "R3 unmask again");

        // R9 out-of-range number aliasing 37 in its low bits
        wr(0, A_ENC, 32'd101);
        rd(0, A_ACK, 32'd37, "R9 out of range ignored");
        wr(0, A_MKS, 32'd40);
        rd(0, A_ACK, 32'd37, "R9 count value ignored");

        // R8 timing with source edge
        src_irq[37] = 1'b0;
        @(negedge clk);
        check("R8 irq follows source low", {30'd0, cpu_irq}, 32'd0);
        src_irq[37] = 1'b1;
        @(negedge clk);
        check("R8 irq follows source high", {30'd0, cpu_irq}, 32'd1);

        repeat (2) @(negedge clk);
        check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule